// File: doc/BRIEF.md
# Trap and Subroutine Control-Transfer Unit

This block works out where a 16-bit processor goes next after it issues one of its control-transfer instructions. It also works out what goes into the fixed link register, R7, at the same time. The unit handles four cases:

- a system-call trap, which reads its target from a vector table in low memory;
- a subroutine call whose target is relative to the PC;
- a subroutine call whose target comes from a base register;
- a return, which is a plain jump through R7.

The fetch stage supplies the instruction word and the already-incremented PC with a one-cycle `instr_valid` pulse. The unit then drives a PC load strobe and a target value. For trap and call it also drives an R7 write strobe with the return address. A `done` pulse tells the sequencer that the transfer has completed.

A call or return completes in the cycle after issue. A trap first places a read request on a single-port memory interface. It holds that request until the memory acknowledges, and it loads the PC in the cycle after the acknowledge. `done` follows in the next cycle. While a trap is in flight the unit ignores new issue pulses.

Top module: `xfer_ctl_unit`

## Requirements
- R1: After reset, `pc_load`, `link_we`, `done` and `mem_req` are all low.
- R2: Decode uses `instr[15:12]`. 1111 is a trap, 0100 is a call, and 1100 is a return only when `instr[8:6]` is 111. Any other word, including 1100 with another base field, leaves `pc_load`, `link_we`, `done` and `mem_req` low.
- R3: A call with `instr[11]`=1 takes its target from `pc_next` plus `instr[10:0]` sign-extended, wrapping modulo 2^16. `pc_load`, `pc_value` and `done` appear in the cycle after issue.
- R4: A call with `instr[11]`=0 takes its target from the register selected by `instr[8:6]`, read on `rf_rd_addr`/`rf_rd_data` in the issue cycle. With base 7 this is the value R7 held before the call's own link write.
- R5: A call raises `link_we` in its `pc_load` cycle, with `link_data` equal to `pc_next` at issue.
- R6: A return loads the contents of R7 (read as register index 7) into the PC one cycle after issue and does not raise `link_we`.
- R7: A trap raises `mem_req` in the cycle after issue. `mem_addr` is `instr[7:0]` zero-extended to 16 bits. Both stay unchanged until `mem_ack` is sampled high.
- R8: In the cycle after `mem_ack` is sampled high during a trap, `pc_load` is high and `pc_value` holds the `mem_rdata` captured with that acknowledge. `link_we` is high in the same cycle with `link_data` equal to `pc_next` at issue.
- R9: A trap asserts `done` exactly one cycle after its `pc_load` cycle and never earlier.
- R10: From the cycle after a trap issue through its `done` cycle, `instr_valid` is ignored and no further `pc_load` occurs.
- R11: `link_we` is never high without `pc_load`. `done` is high only in a `pc_load` cycle or the cycle just after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | One-cycle issue pulse |
| instr | input | 16 | Instruction word |
| pc_next | input | 16 | PC already incremented past the instruction |
| rf_rd_addr | output | 3 | Register-file read index (`instr[8:6]`) |
| rf_rd_data | input | 16 | Register-file read data, combinational |
| mem_req | output | 1 | Vector-table read request, held until acknowledged |
| mem_addr | output | 16 | Vector-table address |
| mem_ack | input | 1 | Read acknowledge; data valid with it |
| mem_rdata | input | 16 | Read data |
| pc_load | output | 1 | Load `pc_value` into the PC |
| pc_value | output | 16 | New PC |
| link_we | output | 1 | Write `link_data` into R7 |
| link_data | output | 16 | Return address |
| done | output | 1 | Transfer complete |

## Verification
The bench builds the unit with its default parameters: a 16-bit word, 3-bit register index, 11-bit call offset, 8-bit vector, link index 7 and a vector table at address zero. With these values the offsets +1023 and -1024 and the wrap past xFFFF and below x0000 are all reachable. So are the top table entry, vector xFF, and a register call through R7 itself. Trap acknowledges arrive after zero, one and several wait cycles. Issue pulses are injected while the trap is pending and in its load cycle to show that they are ignored.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    XK_NONE = 2'd0,
    XK_TRAP = 2'd1,
    XK_CALL = 2'd2,
    XK_RET  = 2'd3
  } xfer_kind_e;

  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_FETCH = 2'd1,
    TS_LOAD  = 2'd2,
    TS_FIN   = 2'd3
  } trap_st_e;

  localparam logic [3:0] OPC_TRAP = 4'b1111;
  localparam logic [3:0] OPC_CALL = 4'b0100;
  localparam logic [3:0] OPC_JUMP = 4'b1100;

endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int REG_IDX_W = 3,
  parameter int BASE_LSB  = 6,
  parameter int OFS_W     = 11,
  parameter int VEC_W     = 8,
  parameter int LINK_IDX  = 7
) (
  input  logic [WORD_W-1:0]    instr,
  input  logic                 instr_valid,
  input  logic                 busy,
  output xfer_kind_e           kind,
  output logic                 rel_mode,
  output logic [REG_IDX_W-1:0] base_idx,
  output logic [OFS_W-1:0]     ofs,
  output logic [VEC_W-1:0]     vec
);

  localparam int OPC_LSB = WORD_W - 4;

  logic [3:0] opc;

  assign opc      = instr[WORD_W-1:OPC_LSB];
  assign rel_mode = instr[OFS_W];
  assign base_idx = instr[BASE_LSB +: REG_IDX_W];
  assign ofs      = instr[OFS_W-1:0];
  assign vec      = instr[VEC_W-1:0];

  always_comb begin
    kind = XK_NONE;
    if (instr_valid && !busy) begin
      unique case (opc)
        OPC_TRAP: kind = XK_TRAP;
        OPC_CALL: kind = XK_CALL;
        OPC_JUMP: if (base_idx == REG_IDX_W'(LINK_IDX)) kind = XK_RET;
        default:  kind = XK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/xfer_target.sv
module xfer_target
  import xfer_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OFS_W  = 11
) (
  input  xfer_kind_e        kind,
  input  logic              rel_mode,
  input  logic [WORD_W-1:0] pc_next,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [WORD_W-1:0] base_data,
  output logic [WORD_W-1:0] target
);

  localparam int EXT_W = WORD_W - OFS_W;

  function automatic logic [WORD_W-1:0] sext_ofs(input logic [OFS_W-1:0] o);
    return {{EXT_W{o[OFS_W-1]}}, o};
  endfunction

  // Sum is truncated to WORD_W bits, so it wraps modulo 2^WORD_W.
  function automatic logic [WORD_W-1:0] rel_dest(input logic [WORD_W-1:0] pc,
                                                 input logic [OFS_W-1:0]  o);
    return pc + sext_ofs(o);
  endfunction

  always_comb begin
    if (kind == XK_CALL && rel_mode) target = rel_dest(pc_next, ofs);
    else                             target = base_data;
  end

endmodule

// File: rtl/xfer_trap_seq.sv
module xfer_trap_seq
  import xfer_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int VEC_W      = 8,
  parameter int TABLE_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VEC_W-1:0]  vec,
  input  logic [WORD_W-1:0] pc_next,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  output logic              busy,
  output logic              trap_load,
  output logic              trap_done,
  output logic [WORD_W-1:0] trap_pc,
  output logic [WORD_W-1:0] trap_link
);

  localparam int PAD_W = WORD_W - VEC_W;

  trap_st_e          st;
  logic [WORD_W-1:0] tbl_addr;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] link_q;
  logic [WORD_W-1:0] tgt_q;

  if (TABLE_BASE == 0) begin : g_table_zero
    assign tbl_addr = {{PAD_W{1'b0}}, vec};
  end else begin : g_table_based
    assign tbl_addr = WORD_W'(TABLE_BASE) | {{PAD_W{1'b0}}, vec};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= TS_IDLE;
      addr_q <= '0;
      link_q <= '0;
      tgt_q  <= '0;
    end else begin
      unique case (st)
        TS_IDLE: if (start) begin
          st     <= TS_FETCH;
          addr_q <= tbl_addr;
          link_q <= pc_next;
        end
        TS_FETCH: if (mem_ack) begin
          st    <= TS_LOAD;
          tgt_q <= mem_rdata;
        end
        TS_LOAD: st <= TS_FIN;
        TS_FIN:  st <= TS_IDLE;
        default: st <= TS_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == TS_FETCH);
  assign mem_addr  = addr_q;
  assign busy      = (st != TS_IDLE);
  assign trap_load = (st == TS_LOAD);
  assign trap_done = (st == TS_FIN);
  assign trap_pc   = tgt_q;
  assign trap_link = link_q;

endmodule

// File: rtl/xfer_ctl_unit.sv
module xfer_ctl_unit
  import xfer_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int REG_IDX_W  = 3,
  parameter int BASE_LSB   = 6,
  parameter int OFS_W      = 11,
  parameter int VEC_W      = 8,
  parameter int LINK_IDX   = 7,
  parameter int TABLE_BASE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [WORD_W-1:0]    instr,
  input  logic [WORD_W-1:0]    pc_next,
  output logic [REG_IDX_W-1:0] rf_rd_addr,
  input  logic [WORD_W-1:0]    rf_rd_data,
  output logic                 mem_req,
  output logic [WORD_W-1:0]    mem_addr,
  input  logic                 mem_ack,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 pc_load,
  output logic [WORD_W-1:0]    pc_value,
  output logic                 link_we,
  output logic [WORD_W-1:0]    link_data,
  output logic                 done
);

  xfer_kind_e          kind;
  logic                rel_mode;
  logic [OFS_W-1:0]    ofs;
  logic [VEC_W-1:0]    vec;
  logic [WORD_W-1:0]   target;

  // Named internal events, observed by the bound checker.
  logic                busy;
  logic                issue_call;
  logic                issue_ret;
  logic                issue_trap;
  logic                trap_load;
  logic                trap_done;
  logic [WORD_W-1:0]   trap_pc;
  logic [WORD_W-1:0]   trap_link;

  logic                cl_load_q;
  logic                cl_link_q;
  logic [WORD_W-1:0]   cl_pc_q;
  logic [WORD_W-1:0]   cl_ret_q;

  xfer_decode #(
    .WORD_W(WORD_W), .REG_IDX_W(REG_IDX_W), .BASE_LSB(BASE_LSB),
    .OFS_W(OFS_W), .VEC_W(VEC_W), .LINK_IDX(LINK_IDX)
  ) u_decode (
    .instr(instr), .instr_valid(instr_valid), .busy(busy),
    .kind(kind), .rel_mode(rel_mode), .base_idx(rf_rd_addr),
    .ofs(ofs), .vec(vec)
  );

  xfer_target #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_target (
    .kind(kind), .rel_mode(rel_mode), .pc_next(pc_next), .ofs(ofs),
    .base_data(rf_rd_data), .target(target)
  );

  assign issue_call = (kind == XK_CALL);
  assign issue_ret  = (kind == XK_RET);
  assign issue_trap = (kind == XK_TRAP);

  xfer_trap_seq #(.WORD_W(WORD_W), .VEC_W(VEC_W), .TABLE_BASE(TABLE_BASE)) u_trap (
    .clk(clk), .rst_n(rst_n), .start(issue_trap), .vec(vec), .pc_next(pc_next),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .busy(busy), .trap_load(trap_load),
    .trap_done(trap_done), .trap_pc(trap_pc), .trap_link(trap_link)
  );

  // Single-cycle path for call and return: the base register is sampled in
  // the issue cycle, before the link write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_load_q <= 1'b0;
      cl_link_q <= 1'b0;
      cl_pc_q   <= '0;
      cl_ret_q  <= '0;
    end else begin
      cl_load_q <= issue_call || issue_ret;
      cl_link_q <= issue_call;
      if (issue_call || issue_ret) begin
        cl_pc_q  <= target;
        cl_ret_q <= pc_next;
      end
    end
  end

  assign pc_load   = cl_load_q | trap_load;
  assign pc_value  = trap_load ? trap_pc : cl_pc_q;
  assign link_we   = cl_link_q | trap_load;
  assign link_data = trap_load ? trap_link : cl_ret_q;
  assign done      = cl_load_q | trap_done;

endmodule

// File: rtl/xfer_ctl_checker.sv
module xfer_ctl_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_call,
  input logic              issue_ret,
  input logic              issue_trap,
  input logic              busy,
  input logic              trap_load,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [WORD_W-1:0] mem_addr,
  input logic              pc_load,
  input logic              link_we,
  input logic              done
);

  a_r3_call_completes: assert property (@(posedge clk) disable iff (!rst_n)
    issue_call |=> (pc_load && link_we && done));

  a_r6_ret_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ret |=> (pc_load && !link_we && done));

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r7_req_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_trap |=> (mem_req && !pc_load));

  a_r8_load_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (pc_load && link_we && !done));

  a_r9_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    trap_load |=> done);

  a_r10_no_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(issue_call || issue_ret || issue_trap));

  a_r11_link_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> pc_load);

  a_r11_done_near_load: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_load || $past(pc_load)));

  a_r2_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

endmodule

bind xfer_ctl_unit xfer_ctl_checker #(.WORD_W(WORD_W)) u_xfer_chk (
  .clk(clk), .rst_n(rst_n), .issue_call(issue_call), .issue_ret(issue_ret),
  .issue_trap(issue_trap), .busy(busy), .trap_load(trap_load),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .pc_load(pc_load), .link_we(link_we), .done(done)
);

// File: tb/test_xfer_ctl_unit.sv
`timescale 1ns/1ps
module test_xfer_ctl_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_next = '0;
  logic [2:0]  rf_rd_addr;
  logic [15:0] rf_rd_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata;
  logic        pc_load;
  logic [15:0] pc_value;
  logic        link_we;
  logic [15:0] link_data;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] rf [8];

  always #4 clk = ~clk;

  function automatic logic [15:0] table_word(input logic [15:0] a);
    return (a * 16'd37) ^ 16'h5A00;
  endfunction

  assign rf_rd_data = rf[rf_rd_addr];
  assign mem_rdata  = table_word(mem_addr);

  xfer_ctl_unit i_xfer_ctl_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .pc_next(pc_next), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_value(pc_value),
    .link_we(link_we), .link_data(link_data), .done(done)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input logic [15:0] pc);
    instr = w; pc_next = pc; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pc_load", {15'd0, pc_load}, 16'd0);
    chk("R1 link_we", {15'd0, link_we}, 16'd0);
    chk("R1 done",    {15'd0, done},    16'd0);
    chk("R1 mem_req", {15'd0, mem_req}, 16'd0);
  endtask

  task automatic t_call(input string tag, input logic [15:0] w, input logic [15:0] pc,
                        input logic [15:0] exp_pc, input bit exp_link);
    issue(w, pc);
    chk({tag, " pc_load"}, {15'd0, pc_load}, 16'd1);
    chk({tag, " pc_value"}, pc_value, exp_pc);
    chk({tag, " done"}, {15'd0, done}, 16'd1);
    chk({tag, " R5 link_we"}, {15'd0, link_we}, {15'd0, exp_link});
    if (exp_link) chk({tag, " R5 link_data"}, link_data, pc);
    @(negedge clk);
    chk({tag, " R11 pulse end"}, {14'd0, pc_load, done}, 16'd0);
  endtask

  task automatic t_ignored(input string tag, input logic [15:0] w);
    issue(w, 16'h3456);
    chk({tag, " R2 no action"}, {12'd0, pc_load, link_we, done, mem_req}, 16'd0);
  endtask

  task automatic t_trap(input logic [7:0] v, input logic [15:0] pc,
                        input int waits, input bit inject);
    issue({8'hF0, v}, pc);
    chk("R7 mem_req", {15'd0, mem_req}, 16'd1);
    chk("R7 mem_addr", mem_addr, {8'h00, v});
    chk("R9 no early load", {14'd0, pc_load, done}, 16'd0);
    for (int i = 0; i < waits; i++) begin
      if (inject && i == 0) begin
        instr = 16'h4805; pc_next = 16'h1111; instr_valid = 1'b1;
      end
      @(negedge clk);
      instr_valid = 1'b0;
      chk("R7 req held", {15'd0, mem_req}, 16'd1);
      chk("R7 addr held", mem_addr, {8'h00, v});
      chk("R10 ignored while pending", {14'd0, pc_load, done}, 16'd0);
    end
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk("R8 pc_load", {15'd0, pc_load}, 16'd1);
    chk("R8 pc_value", pc_value, table_word({8'h00, v}));
    chk("R8 link_we", {15'd0, link_we}, 16'd1);
    chk("R8 link_data", link_data, pc);
    chk("R9 done not with load", {15'd0, done}, 16'd0);
    chk("R7 req dropped", {15'd0, mem_req}, 16'd0);
    if (inject) begin
      instr = 16'h4000; pc_next = 16'h2222; instr_valid = 1'b1;
    end
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R9 done", {15'd0, done}, 16'd1);
    chk("R10 no load in done cycle", {14'd0, pc_load, link_we}, 16'd0);
    @(negedge clk);
    chk("R9 done pulse end", {13'd0, done, pc_load, mem_req}, 16'd0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) rf[k] = 16'h1000 + 16'(k * 16'h0111);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    // R3: PC-relative calls, including wrap and offset extremes
    t_call("R3 rel +5",       16'h4805, 16'h3000, 16'h3005, 1'b1);
    t_call("R3 rel -1",       16'h4FFF, 16'h3000, 16'h2FFF, 1'b1);
    t_call("R3 rel +1023",    16'h4BFF, 16'h0010, 16'h040F, 1'b1);
    t_call("R3 rel -1024",    16'h4C00, 16'h0100, 16'hFD00, 1'b1);
    t_call("R3 wrap high",    16'h4820, 16'hFFF0, 16'h0010, 1'b1);
    // R4: register-mode calls
    t_call("R4 reg base 2",   16'h4080, 16'h4000, rf[2], 1'b1);
    t_call("R4 reg base 5",   16'h4140, 16'h4100, rf[5], 1'b1);
    rf[7] = 16'hBEEF;
    t_call("R4 reg base 7 old value", 16'h41C0, 16'h5000, 16'hBEEF, 1'b1);
    // R6: return through R7
    rf[7] = 16'h3007;
    t_call("R6 return",       16'hC1C0, 16'h6211, 16'h3007, 1'b0);
    // Back-to-back calls
    instr = 16'h4802; pc_next = 16'h0200; instr_valid = 1'b1;
    @(negedge clk);
    chk("R3 b2b first", pc_value, 16'h0202);
    instr = 16'h4803; pc_next = 16'h0300;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R3 b2b second", pc_value, 16'h0303);
    chk("R3 b2b load", {15'd0, pc_load}, 16'd1);
    @(negedge clk);
    // R2: ignored encodings
    t_ignored("R2 add opcode", 16'h1234);
    t_ignored("R2 jump non-link base", 16'hC0C0);
    t_ignored("R2 opcode 0000", 16'h0FFF);
    // R7 R8 R9 R10: traps
    t_trap(8'h21, 16'h3001, 0, 1'b0);
    t_trap(8'hFF, 16'h7FFE, 1, 1'b1);
    t_trap(8'h00, 16'h0003, 4, 1'b1);
    t_trap(8'h80, 16'hFFFF, 2, 1'b0);
    // call right after a trap completes
    t_call("R3 after trap",   16'h4801, 16'h1000, 16'h1001, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule